// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Register Block

This block is the interrupt and routing register set of an expansion card that hosts two IDE channels. Each channel drives a raw interrupt request into the block. Software arms a channel by writing any value to that channel's trigger address. It disarms the channel by reading from the same address. A separate status byte per channel shows the raw request in bit 0, so a handler can find the channel that raised the request. The single host interrupt is the OR of the two requests, each gated by its own arm bit.

A control latch on its own write strobe does two jobs. Bit 0 steers the shared DMA signals to one of the two channels. Bit 5 opens an extended access window. A fixed 4-bit board identity appears one bit per word at four consecutive word addresses. Each word returns its identity bit in bit 0, least significant bit first. The identity is visible only while the window is closed. Writing zero to the latch closes the window, routes DMA to the first channel and makes the identity readable again.

Top module: `dual_ide_irq_regs`

## Requirements
- R1: After reset both arm bits and the control latch are 0. host_irq, dma_chan, window_open and rdata are all 0.
- R2: A write of any data to 0x2200 arms channel 1, and a write to 0x3200 arms channel 2. The arm bit takes effect from the clock edge that samples the write.
- R3: A read of 0x2200 (channel 1) or 0x3200 (channel 2) disarms that channel and returns 0x00. A single one-cycle read strobe clears the arm bit. Repeated reads leave it cleared.
- R4: A read of 0x2290 (channel 1) or 0x3290 (channel 2) returns the channel's raw request in bit 0, with bits 7:1 zero. This read does not change the arm state.
- R5: host_irq is high exactly when some channel has both its raw request and its arm bit set.
- R6: A raw request held high while its channel is disarmed does not reach host_irq. It appears in the cycle after the arming write is sampled.
- R7: A control-latch write sets dma_chan from data bit 0 (0 = channel 1, 1 = channel 2) and window_open from data bit 5. All other data bits are ignored.
- R8: Writing 0x00 to the control latch closes the window and routes DMA to channel 1.
- R9: While the window is closed, reads of 0x2280, 0x2284, 0x2288 and 0x228C return bits 0, 1, 2 and 3 of BOARD_TYPE (default 3) in bit 0. While the window is open these reads return 0x00.
- R10: Reads of unmapped addresses return 0x00. Bus writes to a status address or to any other non-trigger address do not change the arm state.
- R11: Read data is registered. rdata changes only at a clock edge that samples a read strobe, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 14 | Byte address within the card window |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 8 | Write data (ignored by trigger addresses) |
| bus_rdata | output | 8 | Registered read data |
| ctl_wr | input | 1 | Write strobe for the control latch |
| ctl_wdata | input | 8 | Control latch data |
| raw_req | input | 2 | Raw interrupt request per channel |
| host_irq | output | 1 | Combined gated interrupt |
| dma_chan | output | 1 | Channel that receives the shared DMA signals |
| window_open | output | 1 | Extended access window enabled |

## Verification
Each register result is due one edge after the strobe that causes it. A read's data appears in bus_rdata just after the edge that samples bus_rd. The monitor compares it 1 ns after that edge against the value the driver queued. Arm and latch changes show at host_irq, dma_chan and window_open after the same edge, and the bench samples them at the following falling edge. A raw-request change reaches host_irq with no register in the path. The bench therefore checks it at the falling edge after the input is driven.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
    localparam int ADDR_W  = 14;
    localparam int DATA_W  = 8;
    localparam int NUM_CH  = 2;
    localparam int ID_W    = 4;
    localparam int IDX_W   = $clog2(ID_W);

    localparam logic [ADDR_W-1:0] TRIG_BASE  = 14'h2200;
    localparam logic [ADDR_W-1:0] CH_STRIDE  = 14'h1000;
    localparam logic [ADDR_W-1:0] STAT_DELTA = 14'h0090;
    localparam logic [ADDR_W-1:0] ID_BASE    = 14'h2280;
    localparam logic [ADDR_W-1:0] ID_STEP    = 14'h0004;

    localparam int SEL_CHAN_BIT = 0;
    localparam int SEL_WIN_BIT  = 5;

    typedef struct packed {
        logic win;
        logic chan;
    } sel_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;
endpackage

// File: rtl/ide_irq_decode.sv
module ide_irq_decode
    import ide_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [NUM_CH-1:0] trig_wr,
    output logic [NUM_CH-1:0] trig_rd,
    output logic [NUM_CH-1:0] stat_hit,
    output logic              id_hit,
    output logic [IDX_W-1:0]  id_idx
);
    logic [ID_W-1:0] id_match;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] TRIG_A = TRIG_BASE + ADDR_W'(c) * CH_STRIDE;
        localparam logic [ADDR_W-1:0] STAT_A = TRIG_A + STAT_DELTA;
        assign trig_wr[c]  = wr && (addr == TRIG_A);
        assign trig_rd[c]  = rd && (addr == TRIG_A);
        assign stat_hit[c] = addr == STAT_A;
    end

    for (genvar k = 0; k < ID_W; k++) begin : g_id
        localparam logic [ADDR_W-1:0] ID_A = ID_BASE + ADDR_W'(k) * ID_STEP;
        assign id_match[k] = addr == ID_A;
    end

    always_comb begin
        id_hit = |id_match;
        id_idx = '0;
        for (int k = 0; k < ID_W; k++) begin
            if (id_match[k]) id_idx = IDX_W'(k);
        end
    end
endmodule

// File: rtl/ide_irq_chan.sv
module ide_irq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    input  logic raw_req,
    output logic en_q,
    output logic gated
);
    logic en_d;

    always_comb begin
        en_d = en_q;
        if (disarm)   en_d = 1'b0;
        else if (arm) en_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign gated = raw_req & en_q;

    assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !disarm) |=> en_q);
    assert_disarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> !en_q);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !disarm) |=> $stable(en_q));
endmodule

// File: rtl/ide_irq_sel.sv
module ide_irq_sel
    import ide_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              dma_chan,
    output logic              window_open
);
    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (wr) begin
            sel_d.chan = wdata[SEL_CHAN_BIT];
            sel_d.win  = wdata[SEL_WIN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign dma_chan    = sel_q.chan;
    assign window_open = sel_q.win;

    assert_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (dma_chan == $past(wdata[SEL_CHAN_BIT])) && (window_open == $past(wdata[SEL_WIN_BIT])));
    assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata == '0) |=> (!dma_chan && !window_open));
endmodule

// File: rtl/dual_ide_irq_regs.sv
module dual_ide_irq_regs
    import ide_irq_pkg::*;
#(
    parameter logic [ID_W-1:0] BOARD_TYPE = 4'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic [NUM_CH-1:0] raw_req,
    output logic              host_irq,
    output logic              dma_chan,
    output logic              window_open
);
    logic [NUM_CH-1:0] trig_wr, trig_rd, stat_hit, en, gated;
    logic              id_hit;
    logic [IDX_W-1:0]  id_idx;
    rd_t               rd_d, rd_q;

    ide_irq_decode u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .trig_wr(trig_wr), .trig_rd(trig_rd), .stat_hit(stat_hit),
        .id_hit(id_hit), .id_idx(id_idx)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ide_irq_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .arm(trig_wr[c]), .disarm(trig_rd[c]),
            .raw_req(raw_req[c]), .en_q(en[c]), .gated(gated[c])
        );
    end

    ide_irq_sel u_sel (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .dma_chan(dma_chan), .window_open(window_open)
    );

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            rd_d.rdata = '0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (stat_hit[c]) rd_d.rdata[0] = raw_req[c];
            end
            if (id_hit && !window_open) rd_d.rdata[0] = BOARD_TYPE[id_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;
    assign host_irq  = |gated;

    assert_trig_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_rd) |=> bus_rdata == '0);
    assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !host_irq);
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_dual_ide_irq_regs.sv
`timescale 1ns/100ps
module tb_dual_ide_irq_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [1:0]  raw_req = '0;
    logic        host_irq, dma_chan, window_open;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    dual_ide_irq_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .raw_req(raw_req),
        .host_irq(host_irq), .dma_chan(dma_chan), .window_open(window_open)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares every read result 1 ns after the sampling edge
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                #1;
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R11 unexpected read actual=%h expected=none", bus_rdata);
                end else begin
                    check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic bus_write(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0; bus_addr = '0;
    endtask

    task automatic bus_read(input logic [13:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); bus_rd = 1'b0; bus_addr = '0;
    endtask

    task automatic ctl_write(input logic [7:0] d);
        @(negedge clk); ctl_wdata = d; ctl_wr = 1'b1;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic set_raw(input logic [1:0] r);
        @(negedge clk); raw_req = r;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 host_irq", {7'b0, host_irq}, 8'h00);
        check("R1 dma_chan", {7'b0, dma_chan}, 8'h00);
        check("R1 window_open", {7'b0, window_open}, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);

        set_raw(2'b11);
        check("R6 disarmed raw hidden", {7'b0, host_irq}, 8'h00);
        bus_read(14'h2290, 8'h01, "R4 status ch1");
        bus_read(14'h3290, 8'h01, "R4 status ch2");
        check("R4 status read keeps disarmed", {7'b0, host_irq}, 8'h00);

        bus_read(14'h2280, 8'h01, "R9 id bit0");
        bus_read(14'h2284, 8'h01, "R9 id bit1");
        bus_read(14'h2288, 8'h00, "R9 id bit2");
        bus_read(14'h228C, 8'h00, "R9 id bit3");

        bus_write(14'h2200, 8'hA5);
        check("R2 R6 arm ch1 shows irq", {7'b0, host_irq}, 8'h01);
        set_raw(2'b10);
        check("R5 ch2 disarmed", {7'b0, host_irq}, 8'h00);
        bus_write(14'h3200, 8'h00);
        check("R2 arm ch2 any data", {7'b0, host_irq}, 8'h01);

        bus_read(14'h2200, 8'h00, "R3 trigger read ch1 data");
        set_raw(2'b01);
        check("R3 ch1 disarmed by read", {7'b0, host_irq}, 8'h00);
        set_raw(2'b10);
        check("R5 ch2 still armed", {7'b0, host_irq}, 8'h01);
        bus_read(14'h3200, 8'h00, "R3 trigger read ch2 data");
        check("R3 ch2 disarmed by read", {7'b0, host_irq}, 8'h00);
        bus_read(14'h3200, 8'h00, "R3 repeat read");
        check("R3 stays disarmed", {7'b0, host_irq}, 8'h00);

        set_raw(2'b01);
        bus_write(14'h2200, 8'h3C);
        check("R6 rearm shows held request", {7'b0, host_irq}, 8'h01);
        bus_read(14'h2290, 8'h01, "R4 status while armed");
        check("R4 status read keeps armed", {7'b0, host_irq}, 8'h01);
        set_raw(2'b00);
        bus_read(14'h2290, 8'h00, "R4 status low");
        check("R5 no request no irq", {7'b0, host_irq}, 8'h00);
        set_raw(2'b01);
        bus_read(14'h2200, 8'h00, "R3 single read");
        check("R3 single strobe clears", {7'b0, host_irq}, 8'h00);

        ctl_write(8'h21);
        check("R7 dma_chan set", {7'b0, dma_chan}, 8'h01);
        check("R7 window set", {7'b0, window_open}, 8'h01);
        bus_read(14'h2280, 8'h00, "R9 id hidden while window open");
        ctl_write(8'hDE);
        check("R7 other bits ignored chan", {7'b0, dma_chan}, 8'h00);
        check("R7 other bits ignored win", {7'b0, window_open}, 8'h00);
        ctl_write(8'h21);
        ctl_write(8'h00);
        check("R8 zero routes ch1", {7'b0, dma_chan}, 8'h00);
        check("R8 zero closes window", {7'b0, window_open}, 8'h00);
        bus_read(14'h2280, 8'h01, "R8 id readable again");

        bus_write(14'h2290, 8'hFF);
        check("R10 status write no arm", {7'b0, host_irq}, 8'h00);
        bus_write(14'h2201, 8'hFF);
        check("R10 near write no arm", {7'b0, host_irq}, 8'h00);
        bus_read(14'h0100, 8'h00, "R10 unmapped read");
        bus_read(14'h2284, 8'h01, "R11 read before idle");
        repeat (3) @(negedge clk);
        check("R11 rdata holds", bus_rdata, 8'h01);

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R11 pending reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule